// File: doc/BRIEF.md
# T1/E1 Receive Line Decoder

This block is the receive front end of a T1/E1 framer. It samples the positive and negative line rails with the clock recovered from the line. Every clock period it turns the rails into one unipolar data bit. In single-rail format only the positive rail carries NRZ data. In the two dual-rail formats, NRZ or RZ, the rails carry bipolar marks. For those formats the block tracks the polarity of the last mark and flags bipolar violations. It also flags the illegal case where both rails are active in the same bit period.

When the matching mode and enable are set, the block removes zero-substitution codes before the bits leave it: B8ZS in T1 mode and HDB3 in E1 mode. To allow this, decoded bits pass through a short window whose depth depends on the active code. That depth is eight bits for B8ZS, four bits for HDB3 and one bit otherwise.

The configuration is captured only while reset is held. The outputs are a data bit with a valid strobe, a violation flag and a code-error flag.

Top module: `rxl_decoder`

## Requirements
- R1: With `fmt_i` = 2'b00 (single-rail NRZ), `data_o` follows `pos_i`. `neg_i` has no effect, and `bpv_o` and `code_err_o` stay low.
- R2: With `fmt_i` = 2'b01 (dual NRZ) or 2'b10/2'b11 (dual RZ), a mark on exactly one rail decodes to 1 and no mark decodes to 0. Marks on both rails decode to 1 with `code_err_o` high for that bit.
- R3: In the NRZ formats, `fall_edge_i` = 1 samples the rails on the falling clock edge and `fall_edge_i` = 0 samples them on the rising edge.
- R4: In the dual RZ format, the rails are sampled on the rising edge whatever the value of `fall_edge_i`.
- R5: In dual-rail formats, a mark with the same polarity as the previous mark raises `bpv_o` for that bit, and the bit still decodes to 1. The first mark after reset is never a violation. A code-error bit does not change the tracked polarity.
- R6: With dual rails, `t1_mode_i` = 1 and `b8_en_i` = 1, the eight-bit sequence zero, zero, zero, violation, normal mark, zero, violation, normal mark is output as eight zeros with no flags. In any other mode `b8_en_i` has no effect.
- R7: With dual rails, `t1_mode_i` = 0 and `hdb3_en_i` = 1, two zeros followed by a violation are output as zeros. A normal mark just before those two zeros is also cleared. In T1 mode `hdb3_en_i` has no effect.
- R8: The bit sampled at rising edge k appears after rising edge k+D, where D is 8 with B8ZS active, 4 with HDB3 active and 1 otherwise. `valid_o` rises with the first sampled bit and stays high until reset.
- R9: The configuration inputs are captured only while `rst` is high. Changes made after reset is released have no effect.
- R10: While `rst` is high, and on the edge after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_line | input | 1 | Clock recovered from the line |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| pos_i | input | 1 | Positive rail, or the NRZ data in single-rail format |
| neg_i | input | 1 | Negative rail |
| fmt_i | input | 2 | Rail format: 00 single NRZ, 01 dual NRZ, 1x dual RZ |
| fall_edge_i | input | 1 | NRZ formats: sample on the falling edge |
| t1_mode_i | input | 1 | 1 = T1 operation, 0 = E1 operation |
| b8_en_i | input | 1 | Enable B8ZS removal (T1 only) |
| hdb3_en_i | input | 1 | Enable HDB3 removal (E1 only) |
| data_o | output | 1 | Decoded unipolar bit |
| valid_o | output | 1 | Decoded bit is valid |
| bpv_o | output | 1 | Bipolar violation not part of a substitution |
| code_err_o | output | 1 | Both rails were active in this bit |

## Verification
The hardest situation to reach is a substitution sequence that is correct relative to a polarity set by earlier traffic. The substitution must then be told apart from a nearby violation that is not part of any code. The bench builds the rail streams symbol by symbol, so each violation's polarity is fixed against the mark before it. It then places an isolated violation two bits after a completed substitution. The falling-edge choice is made visible by changing the rails in mid-bit, so that the two sampling edges see different symbols.

// File: rtl/rxl_pkg.sv
`timescale 1ns/1ps
package rxl_pkg;

  localparam int B8_SPAN = 8;
  localparam int HD_SPAN = 4;

  typedef enum logic [1:0] {
    FMT_SINGLE   = 2'b00,
    FMT_DUAL_NRZ = 2'b01,
    FMT_DUAL_RZ  = 2'b10,
    FMT_DUAL_RZ2 = 2'b11
  } rail_fmt_e;

  typedef struct packed {
    rail_fmt_e fmt;
    logic      fall_edge;
    logic      t1_mode;
    logic      b8_en;
    logic      hd_en;
  } cfg_t;

  typedef struct packed {
    logic v;
    logic mark;
    logic viol;
    logic err;
  } sym_t;

  function automatic logic fmt_dual(rail_fmt_e f);
    return f != FMT_SINGLE;
  endfunction

  function automatic logic take_fall(cfg_t c);
    return c.fall_edge && (c.fmt == FMT_SINGLE || c.fmt == FMT_DUAL_NRZ);
  endfunction

  function automatic logic b8_active(cfg_t c);
    return fmt_dual(c.fmt) && c.t1_mode && c.b8_en;
  endfunction

  function automatic logic hd_active(cfg_t c);
    return fmt_dual(c.fmt) && !c.t1_mode && c.hd_en;
  endfunction

  function automatic int unsigned out_depth(cfg_t c);
    if (b8_active(c)) return B8_SPAN;
    if (hd_active(c)) return HD_SPAN;
    return 1;
  endfunction

  function automatic logic is_v(sym_t s);
    return s.mark && s.viol;
  endfunction

  function automatic logic is_b(sym_t s);
    return s.mark && !s.viol && !s.err;
  endfunction

  // window index 0 is the newest symbol
  function automatic logic b8zs_hit(sym_t [B8_SPAN-1:0] w);
    return !w[7].mark && !w[6].mark && !w[5].mark && is_v(w[4]) &&
           is_b(w[3]) && !w[2].mark && is_v(w[1]) && is_b(w[0]);
  endfunction

  function automatic logic hdb3_hit(sym_t [HD_SPAN-1:0] w);
    return is_v(w[0]) && !w[1].mark && !w[2].mark;
  endfunction

endpackage

// File: rtl/rxl_capture.sv
`timescale 1ns/1ps
module rxl_capture (
  input  logic clk,
  input  logic rst,
  input  logic fall_sel,
  input  logic pos_i,
  input  logic neg_i,
  output logic s_pos,
  output logic s_neg,
  output logic s_v
);
  logic [1:0] fall_q;

  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= {pos_i, neg_i};
  end

  // both paths land on the rising edge, so latency does not depend on the edge choice
  always_ff @(posedge clk) begin
    if (rst) begin
      s_pos <= 1'b0;
      s_neg <= 1'b0;
      s_v   <= 1'b0;
    end else begin
      {s_pos, s_neg} <= fall_sel ? fall_q : {pos_i, neg_i};
      s_v            <= 1'b1;
    end
  end
endmodule

// File: rtl/rxl_classify.sv
`timescale 1ns/1ps
module rxl_classify
  import rxl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dual,
  input  logic s_pos,
  input  logic s_neg,
  input  logic s_v,
  output sym_t sym
);
  logic last_pol, lp_ok;
  logic mark_w, err_w;

  always_comb begin
    mark_w   = dual ? (s_pos | s_neg) : s_pos;
    err_w    = dual & s_pos & s_neg;
    sym.v    = s_v;
    sym.mark = mark_w;
    sym.err  = err_w;
    sym.viol = dual & mark_w & !err_w & lp_ok & (s_pos == last_pol);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pol <= 1'b0;
      lp_ok    <= 1'b0;
    end else if (s_v && dual && mark_w && !err_w) begin
      last_pol <= s_pos;
      lp_ok    <= 1'b1;
    end
  end
endmodule

// File: rtl/rxl_subst.sv
`timescale 1ns/1ps
module rxl_subst
  import rxl_pkg::*;
#(
  parameter int WIN = B8_SPAN,
  localparam int IDX_W = $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             b8_on,
  input  logic             hd_on,
  input  logic [IDX_W-1:0] tap_idx,
  input  sym_t             sym_in,
  output sym_t             tap
);
  sym_t [WIN-1:0] sr, nx;
  logic b8_hit, hd_hit;

  always_comb begin
    nx     = {sr[WIN-2:0], sym_in};
    b8_hit = b8_on && b8zs_hit(nx[B8_SPAN-1:0]);
    hd_hit = hd_on && hdb3_hit(nx[HD_SPAN-1:0]);
    if (b8_hit) begin
      for (int j = 0; j < B8_SPAN; j++) begin
        nx[j].mark = 1'b0;
        nx[j].viol = 1'b0;
      end
    end
    if (hd_hit) begin
      for (int j = 0; j < HD_SPAN - 1; j++) begin
        nx[j].mark = 1'b0;
        nx[j].viol = 1'b0;
      end
      if (is_b(nx[HD_SPAN-1])) nx[HD_SPAN-1].mark = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= nx;
  end

  assign tap = sr[tap_idx];
endmodule

// File: rtl/rxl_decoder.sv
`timescale 1ns/1ps
module rxl_decoder
  import rxl_pkg::*;
#(
  parameter int WIN = B8_SPAN,
  localparam int IDX_W = $clog2(WIN)
) (
  input  logic       clk_line,
  input  logic       rst,
  input  logic       pos_i,
  input  logic       neg_i,
  input  logic [1:0] fmt_i,
  input  logic       fall_edge_i,
  input  logic       t1_mode_i,
  input  logic       b8_en_i,
  input  logic       hdb3_en_i,
  output logic       data_o,
  output logic       valid_o,
  output logic       bpv_o,
  output logic       code_err_o
);
  cfg_t cfg_q;
  logic cfg_dual_w, fall_sel_w, b8_on_w, hd_on_w;
  logic [IDX_W-1:0] tap_idx_w;
  logic s_pos, s_neg, s_v;
  sym_t sym_w, tap_w;

  always_ff @(posedge clk_line) begin
    if (rst) begin
      cfg_q.fmt       <= rail_fmt_e'(fmt_i);
      cfg_q.fall_edge <= fall_edge_i;
      cfg_q.t1_mode   <= t1_mode_i;
      cfg_q.b8_en     <= b8_en_i;
      cfg_q.hd_en     <= hdb3_en_i;
    end
  end

  assign cfg_dual_w = fmt_dual(cfg_q.fmt);
  assign fall_sel_w = take_fall(cfg_q);
  assign b8_on_w    = b8_active(cfg_q);
  assign hd_on_w    = hd_active(cfg_q);
  assign tap_idx_w  = IDX_W'(out_depth(cfg_q) - 1);

  rxl_capture u_cap (
    .clk(clk_line), .rst(rst), .fall_sel(fall_sel_w),
    .pos_i(pos_i), .neg_i(neg_i),
    .s_pos(s_pos), .s_neg(s_neg), .s_v(s_v)
  );

  rxl_classify u_cls (
    .clk(clk_line), .rst(rst), .dual(cfg_dual_w),
    .s_pos(s_pos), .s_neg(s_neg), .s_v(s_v), .sym(sym_w)
  );

  rxl_subst #(.WIN(WIN)) u_sub (
    .clk(clk_line), .rst(rst), .b8_on(b8_on_w), .hd_on(hd_on_w),
    .tap_idx(tap_idx_w), .sym_in(sym_w), .tap(tap_w)
  );

  assign data_o     = tap_w.mark;
  assign valid_o    = tap_w.v;
  assign bpv_o      = tap_w.viol;
  assign code_err_o = tap_w.err;
endmodule

// File: rtl/rxl_decoder_chk.sv
`timescale 1ns/1ps
module rxl_decoder_chk
  import rxl_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic valid_o,
  input logic data_o,
  input logic bpv_o,
  input logic code_err_o,
  input logic dual_w,
  input cfg_t cfg_q
);
  p_single_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !dual_w |-> (!bpv_o && !code_err_o));

  p_err_dual_r2: assert property (@(posedge clk) disable iff (rst)
    code_err_o |-> dual_w);

  p_bpv_is_mark_r5: assert property (@(posedge clk) disable iff (rst)
    bpv_o |-> (data_o && !code_err_o));

  p_valid_hold_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o);

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(cfg_q));

  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (!valid_o && !data_o && !bpv_o && !code_err_o));
endmodule

bind rxl_decoder rxl_decoder_chk u_chk (
  .clk(clk_line), .rst(rst), .valid_o(valid_o), .data_o(data_o),
  .bpv_o(bpv_o), .code_err_o(code_err_o), .dual_w(cfg_dual_w), .cfg_q(cfg_q)
);

// File: tb/sim_rxl_decoder.sv
`timescale 1ns/1ps
module sim_rxl_decoder;
  localparam int CLK_T = 20;
  localparam int NC = 12;
  localparam int LEN = 16;

  logic clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  logic rst = 1'b1;
  logic pos_i = 1'b0, neg_i = 1'b0;
  logic [1:0] fmt_i = 2'b01;
  logic fall_edge_i = 1'b0, t1_mode_i = 1'b1, b8_en_i = 1'b0, hdb3_en_i = 1'b0;
  logic data_o, valid_o, bpv_o, code_err_o;

  int errs = 0;
  int checks = 0;

  rxl_decoder u0 (
    .clk_line(clk), .rst(rst), .pos_i(pos_i), .neg_i(neg_i), .fmt_i(fmt_i),
    .fall_edge_i(fall_edge_i), .t1_mode_i(t1_mode_i), .b8_en_i(b8_en_i),
    .hdb3_en_i(hdb3_en_i), .data_o(data_o), .valid_o(valid_o),
    .bpv_o(bpv_o), .code_err_o(code_err_o)
  );

  // symbols: + positive mark, - negative mark, 0 space, X both rails
  localparam logic [1:0] C_FMT  [NC] = '{2'b01, 2'b00, 2'b01, 2'b01, 2'b01, 2'b01,
                                         2'b01, 2'b01, 2'b10, 2'b01, 2'b10, 2'b01};
  localparam logic       C_FALL [NC] = '{0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0};
  localparam logic       C_T1   [NC] = '{1, 1, 1, 0, 0, 0, 1, 1, 1, 1, 1, 1};
  localparam logic       C_B8   [NC] = '{0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0};
  localparam logic       C_HD   [NC] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1};
  localparam logic       C_FLIP [NC] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam logic [127:0] C_A [NC] = '{
    "+-++0-0-+X-00000", "+-X0++-0X+++0-0+", "+000+-0-+--00000", "+000+-00-+0+0000",
    "+000+-00-+0+0000", "+000000000000000", "+-+-0000+-+-0000", "+-+-0000+-+-0000",
    "+-+-0000+-+-0000", "+000+-0-+--00000", "+000+-0-+--00000", "+000+-00-+0+0000"};
  localparam logic [127:0] C_B [NC] = '{
    "+-++0-0-+X-00000", "+-X0++-0X+++0-0+", "+000+-0-+--00000", "+000+-00-+0+0000",
    "+000+-00-+0+0000", "+000000000000000", "0000+-+-0000+-+-", "0000+-+-0000+-+-",
    "0000+-+-0000+-+-", "+000+-0-+--00000", "+000+-0-+--00000", "+000+-00-+0+0000"};
  localparam logic [127:0] C_D [NC] = '{
    "1111010111100000", "1010110011110001", "1000000001100000", "1000000001010000",
    "1000110011010000", "1000000000000000", "1111000011110000", "0000111100001111",
    "0000111100001111", "1000110111100000", "1000000001100000", "1000110011010000"};
  localparam logic [127:0] C_V [NC] = '{
    "0001000100000000", "0000000000000000", "0000000000100000", "0000000000010000",
    "0000100010010000", "0000000000000000", "0000000000000000", "0000000000000000",
    "0000000000000000", "0000100100100000", "0000000000100000", "0000100010010000"};
  localparam logic [127:0] C_E [NC] = '{
    "0000000001000000", "0000000000000000", "0000000000000000", "0000000000000000",
    "0000000000000000", "0000000000000000", "0000000000000000", "0000000000000000",
    "0000000000000000", "0000000000000000", "0000000000000000", "0000000000000000"};
  // R2 R5 | R1 | R6 | R7 | R5 | R5 first mark | R3 | R3 | R4 | R9 | R6 RZ | R7 ignored in T1
  localparam string C_TAG [NC] = '{"R2 R5", "R1", "R6", "R7", "R5", "R5", "R3", "R3",
                                   "R4", "R9", "R6", "R7"};

  function automatic logic [7:0] ch(logic [127:0] s, int i);
    return s[8*(LEN-1-i) +: 8];
  endfunction

  task automatic put(logic [7:0] c);
    pos_i = (c == "+") || (c == "X");
    neg_i = (c == "-") || (c == "X");
  endtask

  task automatic check(logic [3:0] got, logic [3:0] exp, string tag, int k, int n);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s case %0d cycle %0d: {valid,data,bpv,err} got %b expected %b",
               tag, k, n, got, exp);
    end
  endtask

  // R8: output lag in clock cycles from drive to observation, D + 1
  function automatic int lag_of(int k);
    if (C_FMT[k] != 2'b00 && C_T1[k] && C_B8[k]) return 9;
    if (C_FMT[k] != 2'b00 && !C_T1[k] && C_HD[k]) return 5;
    return 2;
  endfunction

  task automatic run_case(int k);
    int lat;
    logic [3:0] exp;
    fmt_i = C_FMT[k]; fall_edge_i = C_FALL[k]; t1_mode_i = C_T1[k];
    b8_en_i = C_B8[k]; hdb3_en_i = C_HD[k];
    rst = 1'b1; put("0");
    repeat (3) @(posedge clk);
    lat = lag_of(k);
    for (int n = 0; n < LEN + lat + 1; n++) begin
      @(posedge clk);
      #(CLK_T/4);
      if (n == 0) rst = 1'b0;
      if (n == 2 && C_FLIP[k]) begin
        b8_en_i = 1'b1; hdb3_en_i = 1'b1; fall_edge_i = 1'b1;
      end
      if (n < lat) exp = 4'b0000;  // R8 and R10: nothing valid yet
      else if (n - lat < LEN)
        exp = {1'b1, ch(C_D[k], n-lat) == "1", ch(C_V[k], n-lat) == "1",
               ch(C_E[k], n-lat) == "1"};
      else exp = 4'b1000;
      check({valid_o, data_o, bpv_o, code_err_o}, exp, C_TAG[k], k, n);
      put(n < LEN ? ch(C_A[k], n) : "0");
      @(negedge clk);
      #1;
      put(n < LEN ? ch(C_B[k], n) : "0");
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #(CLK_T/4);
    // R10: reset state
    check({valid_o, data_o, bpv_o, code_err_o}, 4'b0000, "R10", -1, 0);
    for (int k = 0; k < NC; k++) run_case(k);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #(CLK_T/4);
    check({valid_o, data_o, bpv_o, code_err_o}, 4'b0000, "R10", -1, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_T * 100000);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule